// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers a set of interrupt request lines, 32 by default, and reduces them to two requests for a processor core: a fast request and a normal request. Each channel passes through a per-channel enable mask, then is steered either to the fast path or to the normal path. Normal-path channels that are bound to one of the priority-ordered vector slots become vectored requests. All other normal-path channels are non-vectored, and software must poll the status outputs to find their source.

A contiguous group of channels, eight by default starting at channel 7, comes from external pins. Each of these pins has its own sense mode (level or edge) and polarity (high/rising or low/falling). An edge-sensed pin is captured in a sticky flag that software releases with a one-cycle clear pulse. Channel 0 carries the watchdog and always goes to the fast path.

The processor reads `vec_addr` to find the handler. A `vec_read` pulse marks the slot being presented as in service. While that slot is in service, vectored requests at the same or lower priority are held back, and higher-priority slots can still nest on top. An `eoi` pulse retires the highest-priority level that is in service. The register bus that supplies the configuration ports and produces the two pulses sits outside this block.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, no level is in service, `fiq_out` and `irq_out` are 0, and with no request pending `vec_addr` equals `default_addr`.
- R2: A non-external channel appears in `raw_status` as its `irq_in` level, active high, with no added delay.
- R3: An external pin in level mode (`ext_edge_mode`=0) shows in `raw_status` as the pin level when `ext_pol_high`=1, and as the inverted pin level when `ext_pol_high`=0.
- R4: An external pin in edge mode (`ext_edge_mode`=1) sets its `raw_status` bit on the clock edge that first sees a rising edge (`ext_pol_high`=1) or a falling edge (`ext_pol_high`=0). The bit stays set after the pin returns, until an `edge_clr` pulse for that channel clears it at the next clock edge.
- R5: A channel with `ch_enable`=0 still shows in `raw_status`, but it never appears in `fiq_status` or `irq_status` and cannot raise either output.
- R6: An enabled, pending channel with `ch_fast_sel`=1 shows in `fiq_status` and drives `fiq_out`. With `ch_fast_sel`=0 it shows in `irq_status` instead. The two status vectors never overlap.
- R7: Channel 0 is routed to the fast path whatever its `ch_fast_sel` bit is, so `irq_status[0]` is always 0.
- R8: `vec_addr` is the `slot_addr` of the lowest-index enabled slot whose channel is set in `irq_status` and which is not blocked by service. If no such slot exists, `vec_addr` is `default_addr`.
- R9: A `vec_read` pulse with a slot presented marks that slot in service at the next clock edge. From then on, slots of equal or higher index neither appear on `vec_addr` nor raise `irq_out`, while slots of lower index still do.
- R10: An `eoi` pulse clears the lowest-index in-service slot at the next clock edge, and blocked slots become eligible again.
- R11: Any enabled normal-path channel that no enabled slot maps drives `irq_out` high regardless of what is in service.
- R12: A slot with `slot_enable`=0 is ignored. Its channel is treated as non-vectored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_CH | Request lines; external pins at EXT_BASE upward |
| ext_edge_mode | input | NUM_EXT | Per external pin: 1 edge sensed, 0 level sensed |
| ext_pol_high | input | NUM_EXT | Per external pin: 1 rising/high, 0 falling/low |
| ch_enable | input | NUM_CH | Per-channel enable mask |
| ch_fast_sel | input | NUM_CH | Per-channel fast-path select |
| edge_clr | input | NUM_CH | One-cycle clear of captured edge flags |
| slot_enable | input | NUM_SLOTS | Per-slot enable |
| slot_channel | input | NUM_SLOTS x CH_W | Channel bound to each slot |
| slot_addr | input | NUM_SLOTS x ADDR_W | Handler address of each slot |
| default_addr | input | ADDR_W | Address when no vectored slot is presented |
| vec_read | input | 1 | Pulse: processor fetched `vec_addr` |
| eoi | input | 1 | Pulse: end of interrupt service |
| raw_status | output | NUM_CH | Conditioned request before masking |
| fiq_status | output | NUM_CH | Masked requests on the fast path |
| irq_status | output | NUM_CH | Masked requests on the normal path |
| fiq_out | output | 1 | Fast interrupt request |
| irq_out | output | 1 | Normal interrupt request |
| vec_addr | output | ADDR_W | Handler address of the presented slot |

## Verification
The assertions assume that `ext_edge_mode` and `ext_pol_high` change only while the pin is quiet. This keeps a polarity flip from being counted as an edge. They also assume that `edge_clr` is not pulsed in the same cycle as a fresh edge on that channel. The bench changes polarity only with its pins settled, and it waits whole cycles between a pin edge and a clear. It gives each slot a distinct address, so every expected `vec_addr` points to one slot.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
   typedef enum logic {SENSE_LEVEL = 1'b0, SENSE_EDGE = 1'b1} sense_e;

   // one-hot of the lowest set bit of a request vector (width fixed at 64)
   function automatic logic [63:0] lowest_onehot(input logic [63:0] v);
      return v & (~v + 64'd1);
   endfunction
endpackage

// File: rtl/irq_ext_cond.sv
module irq_ext_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic edge_mode,
   input  logic pol_high,
   input  logic clr,
   output logic req
);
   import irq_vec_pkg::*;

   logic norm_lvl;
   logic prev_lvl;
   logic captured;
   sense_e mode;

   assign mode     = sense_e'(edge_mode);
   assign norm_lvl = pol_high ? pin : ~pin;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_lvl <= 1'b0;
         captured <= 1'b0;
      end else begin
         prev_lvl <= norm_lvl;
         if (mode == SENSE_LEVEL)
            captured <= 1'b0;
         else if (norm_lvl && !prev_lvl)
            captured <= 1'b1;
         else if (clr)
            captured <= 1'b0;
      end
   end

   assign req = (mode == SENSE_EDGE) ? captured : norm_lvl;
endmodule

// File: rtl/irq_route.sv
module irq_route #(
   parameter int NUM_CH       = 32,
   parameter int FAST_ONLY_CH = 0
) (
   input  logic [NUM_CH-1:0] raw,
   input  logic [NUM_CH-1:0] enable,
   input  logic [NUM_CH-1:0] fast_sel,
   output logic [NUM_CH-1:0] fast_req,
   output logic [NUM_CH-1:0] norm_req
);
   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic to_fast;
      if (i == FAST_ONLY_CH) begin : g_forced
         assign to_fast = 1'b1;
      end else begin : g_prog
         assign to_fast = fast_sel[i];
      end
      assign fast_req[i] = raw[i] & enable[i] & to_fast;
      assign norm_req[i] = raw[i] & enable[i] & ~to_fast;
   end
endmodule

// File: rtl/irq_slot_arb.sv
module irq_slot_arb #(
   parameter int NUM_CH    = 32,
   parameter int NUM_SLOTS = 16,
   parameter int ADDR_W    = 32,
   localparam int CH_W     = $clog2(NUM_CH)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_CH-1:0]                 norm_req,
   input  logic [NUM_SLOTS-1:0]              slot_enable,
   input  logic [NUM_SLOTS-1:0][CH_W-1:0]    slot_channel,
   input  logic [NUM_SLOTS-1:0][ADDR_W-1:0]  slot_addr,
   input  logic [ADDR_W-1:0]                 default_addr,
   input  logic                              vec_read,
   input  logic                              eoi,
   output logic [NUM_CH-1:0]                 vec_mask,
   output logic                              vec_any,
   output logic [ADDR_W-1:0]                 vec_addr
);
   import irq_vec_pkg::*;

   logic [NUM_SLOTS-1:0] in_service;
   logic [NUM_SLOTS-1:0] slot_pend;
   logic [NUM_SLOTS-1:0] allow;
   logic [NUM_SLOTS-1:0] elig;
   logic [NUM_SLOTS-1:0] sel_oh;
   logic [NUM_SLOTS-1:0] svc_low_oh;
   logic [63:0]          elig_w, svc_w, elig_oh_w, svc_oh_w;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      assign slot_pend[s] = slot_enable[s] & norm_req[slot_channel[s]];
   end

   always_comb begin
      vec_mask = '0;
      for (int s = 0; s < NUM_SLOTS; s++)
         if (slot_enable[s]) vec_mask[slot_channel[s]] = 1'b1;
   end

   // slot s is allowed only if every in-service slot has a larger index
   always_comb begin
      allow = '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
         allow[s] = 1'b1;
         for (int t = 0; t <= s; t++)
            if (in_service[t]) allow[s] = 1'b0;
      end
   end

   assign elig      = slot_pend & allow;
   assign elig_w    = 64'(elig);
   assign svc_w     = 64'(in_service);
   assign elig_oh_w = lowest_onehot(elig_w);
   assign svc_oh_w  = lowest_onehot(svc_w);
   assign sel_oh    = elig_oh_w[NUM_SLOTS-1:0];
   assign svc_low_oh = svc_oh_w[NUM_SLOTS-1:0];
   assign vec_any   = |elig;

   always_comb begin
      vec_addr = default_addr;
      for (int s = 0; s < NUM_SLOTS; s++)
         if (sel_oh[s]) vec_addr = slot_addr[s];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_service <= '0;
      end else begin
         in_service <= (in_service & ~(eoi ? svc_low_oh : '0))
                     | ((vec_read && vec_any) ? sel_oh : '0);
      end
   end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
   parameter int NUM_CH    = 32,
   parameter int NUM_EXT   = 8,
   parameter int EXT_BASE  = 7,
   parameter int NUM_SLOTS = 16,
   parameter int ADDR_W    = 32,
   parameter int WDOG_CH   = 0,
   localparam int CH_W     = $clog2(NUM_CH)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_CH-1:0]                 irq_in,
   input  logic [NUM_EXT-1:0]                ext_edge_mode,
   input  logic [NUM_EXT-1:0]                ext_pol_high,
   input  logic [NUM_CH-1:0]                 ch_enable,
   input  logic [NUM_CH-1:0]                 ch_fast_sel,
   input  logic [NUM_CH-1:0]                 edge_clr,
   input  logic [NUM_SLOTS-1:0]              slot_enable,
   input  logic [NUM_SLOTS-1:0][CH_W-1:0]    slot_channel,
   input  logic [NUM_SLOTS-1:0][ADDR_W-1:0]  slot_addr,
   input  logic [ADDR_W-1:0]                 default_addr,
   input  logic                              vec_read,
   input  logic                              eoi,
   output logic [NUM_CH-1:0]                 raw_status,
   output logic [NUM_CH-1:0]                 fiq_status,
   output logic [NUM_CH-1:0]                 irq_status,
   output logic                              fiq_out,
   output logic                              irq_out,
   output logic [ADDR_W-1:0]                 vec_addr
);
   if (NUM_CH < 2 || NUM_CH > 64) begin : g_bad_ch
      $error("irq_vector_ctrl: NUM_CH must be 2..64");
   end
   if (NUM_SLOTS < 1 || NUM_SLOTS > 64) begin : g_bad_slots
      $error("irq_vector_ctrl: NUM_SLOTS must be 1..64");
   end
   if (EXT_BASE + NUM_EXT > NUM_CH) begin : g_bad_ext
      $error("irq_vector_ctrl: external range exceeds channel count");
   end
   if (WDOG_CH >= NUM_CH) begin : g_bad_wdog
      $error("irq_vector_ctrl: WDOG_CH out of range");
   end

   logic [NUM_CH-1:0] vec_mask;
   logic              vec_any;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_src
      if (i >= EXT_BASE && i < EXT_BASE + NUM_EXT) begin : g_ext
         irq_ext_cond i_cond (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin       (irq_in[i]),
            .edge_mode (ext_edge_mode[i-EXT_BASE]),
            .pol_high  (ext_pol_high[i-EXT_BASE]),
            .clr       (edge_clr[i]),
            .req       (raw_status[i])
         );
      end else begin : g_int
         assign raw_status[i] = irq_in[i];
      end
   end

   irq_route #(.NUM_CH(NUM_CH), .FAST_ONLY_CH(WDOG_CH)) i_route (
      .raw      (raw_status),
      .enable   (ch_enable),
      .fast_sel (ch_fast_sel),
      .fast_req (fiq_status),
      .norm_req (irq_status)
   );

   irq_slot_arb #(.NUM_CH(NUM_CH), .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) i_arb (
      .clk          (clk),
      .rst_n        (rst_n),
      .norm_req     (irq_status),
      .slot_enable  (slot_enable),
      .slot_channel (slot_channel),
      .slot_addr    (slot_addr),
      .default_addr (default_addr),
      .vec_read     (vec_read),
      .eoi          (eoi),
      .vec_mask     (vec_mask),
      .vec_any      (vec_any),
      .vec_addr     (vec_addr)
   );

   assign fiq_out = |fiq_status;
   assign irq_out = vec_any | (|(irq_status & ~vec_mask));
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
   parameter int NUM_CH   = 32,
   parameter int NUM_EXT  = 8,
   parameter int EXT_BASE = 7,
   parameter int WDOG_CH  = 0
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_CH-1:0]  irq_in,
   input logic [NUM_EXT-1:0] ext_edge_mode,
   input logic [NUM_EXT-1:0] ext_pol_high,
   input logic [NUM_CH-1:0]  ch_enable,
   input logic [NUM_CH-1:0]  edge_clr,
   input logic [NUM_CH-1:0]  raw_status,
   input logic [NUM_CH-1:0]  fiq_status,
   input logic [NUM_CH-1:0]  irq_status,
   input logic               irq_out
);
   p_wdog_fast_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_status[WDOG_CH]);

   p_disjoint_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fiq_status & irq_status) == '0);

   p_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((fiq_status | irq_status) & ~ch_enable) == '0);

   p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_status == '0) |-> !irq_out);

   for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
      p_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
         !ext_edge_mode[k] |->
            raw_status[EXT_BASE+k] == (ext_pol_high[k] ? irq_in[EXT_BASE+k] : !irq_in[EXT_BASE+k]));

      p_edge_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (ext_edge_mode[k] && raw_status[EXT_BASE+k] && !edge_clr[EXT_BASE+k])
            |=> (raw_status[EXT_BASE+k] || !ext_edge_mode[k]));
   end
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
   .NUM_CH(NUM_CH), .NUM_EXT(NUM_EXT), .EXT_BASE(EXT_BASE), .WDOG_CH(WDOG_CH)
) i_chk (
   .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ext_edge_mode(ext_edge_mode),
   .ext_pol_high(ext_pol_high), .ch_enable(ch_enable), .edge_clr(edge_clr),
   .raw_status(raw_status), .fiq_status(fiq_status), .irq_status(irq_status),
   .irq_out(irq_out)
);

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
   localparam int NCH = 32, NEXT = 8, EBASE = 7, NSL = 16, AW = 32, CW = 5;

   logic                       clk = 1'b0;
   logic                       rst_n = 1'b0;
   logic [NCH-1:0]             irq_in = '0;
   logic [NEXT-1:0]            ext_edge_mode = '0;
   logic [NEXT-1:0]            ext_pol_high = '1;
   logic [NCH-1:0]             ch_enable = '1;
   logic [NCH-1:0]             ch_fast_sel = '0;
   logic [NCH-1:0]             edge_clr = '0;
   logic [NSL-1:0]             slot_enable = '0;
   logic [NSL-1:0][CW-1:0]     slot_channel = '0;
   logic [NSL-1:0][AW-1:0]     slot_addr;
   logic [AW-1:0]              default_addr = 32'hDEAD_0000;
   logic                       vec_read = 1'b0;
   logic                       eoi = 1'b0;
   logic [NCH-1:0]             raw_status, fiq_status, irq_status;
   logic                       fiq_out, irq_out;
   logic [AW-1:0]              vec_addr;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   irq_vector_ctrl i_irq_vector_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ext_edge_mode(ext_edge_mode),
      .ext_pol_high(ext_pol_high), .ch_enable(ch_enable), .ch_fast_sel(ch_fast_sel),
      .edge_clr(edge_clr), .slot_enable(slot_enable), .slot_channel(slot_channel),
      .slot_addr(slot_addr), .default_addr(default_addr), .vec_read(vec_read),
      .eoi(eoi), .raw_status(raw_status), .fiq_status(fiq_status),
      .irq_status(irq_status), .fiq_out(fiq_out), .irq_out(irq_out),
      .vec_addr(vec_addr)
   );

   function automatic logic [AW-1:0] addr_of(input int s);
      return 32'h0000_1000 + 32'(s) * 32'h10;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset;
      chk(fiq_out == 1'b0, "R1 fiq_out", 64'(fiq_out), 0);
      chk(irq_out == 1'b0, "R1 irq_out", 64'(irq_out), 0);
      chk(vec_addr == default_addr, "R1 vec_addr", 64'(vec_addr), 64'(default_addr));
      chk(raw_status == '0, "R1 raw_status", 64'(raw_status), 0);
   endtask

   task automatic t_internal;
      irq_in[4] = 1'b1; #1;
      chk(raw_status[4], "R2 raw level", 64'(raw_status), 64'h10);
      chk(irq_status[4] && irq_out, "R11 non-vectored irq_out", 64'(irq_out), 1);
      chk(vec_addr == default_addr, "R8 default addr", 64'(vec_addr), 64'(default_addr));
      ch_enable[4] = 1'b0; #1;
      chk(raw_status[4] && !irq_status[4] && !irq_out, "R5 masked", 64'(irq_status), 0);
      ch_enable[4] = 1'b1; irq_in[4] = 1'b0;
      tick(1);
   endtask

   task automatic t_route;
      ch_fast_sel[5] = 1'b1; irq_in[5] = 1'b1; #1;
      chk(fiq_status[5] && fiq_out && !irq_status[5] && !irq_out, "R6 fast route",
          64'(fiq_status), 64'h20);
      irq_in[5] = 1'b0; ch_fast_sel[5] = 1'b0;
      irq_in[0] = 1'b1; #1;
      chk(fiq_out && fiq_status[0] && !irq_status[0], "R7 watchdog fast only",
          64'(irq_status), 0);
      irq_in[0] = 1'b0;
      tick(1);
   endtask

   task automatic t_ext_level;
      // ext 2 = channel 9
      irq_in[9] = 1'b1; #1;
      chk(raw_status[9], "R3 active high", 64'(raw_status[9]), 1);
      ext_pol_high[2] = 1'b0; #1;
      chk(!raw_status[9], "R3 active low pin high", 64'(raw_status[9]), 0);
      irq_in[9] = 1'b0; #1;
      chk(raw_status[9], "R3 active low pin low", 64'(raw_status[9]), 1);
      ext_pol_high[2] = 1'b1;
      tick(2);
   endtask

   task automatic t_ext_edge;
      // ext 3 = channel 10
      ext_edge_mode[3] = 1'b1;
      tick(2);
      irq_in[10] = 1'b1; #1;
      chk(!raw_status[10], "R4 not before edge", 64'(raw_status[10]), 0);
      tick(1);
      chk(raw_status[10], "R4 rising captured", 64'(raw_status[10]), 1);
      irq_in[10] = 1'b0;
      tick(2);
      chk(raw_status[10], "R4 sticky", 64'(raw_status[10]), 1);
      edge_clr[10] = 1'b1; tick(1); edge_clr[10] = 1'b0; #1;
      chk(!raw_status[10], "R4 cleared", 64'(raw_status[10]), 0);
      irq_in[10] = 1'b1; tick(2);
      edge_clr[10] = 1'b1; tick(1); edge_clr[10] = 1'b0;
      ext_pol_high[3] = 1'b0;
      tick(2);
      chk(!raw_status[10], "R4 no edge on polarity flip", 64'(raw_status[10]), 0);
      irq_in[10] = 1'b0;
      tick(1);
      chk(raw_status[10], "R4 falling captured", 64'(raw_status[10]), 1);
      ext_pol_high[3] = 1'b1; ext_edge_mode[3] = 1'b0;
      tick(2);
   endtask

   task automatic t_vector;
      slot_channel[3] = 5'd20; slot_channel[7] = 5'd22; slot_channel[1] = 5'd25;
      slot_enable[3] = 1'b1; slot_enable[7] = 1'b1; slot_enable[1] = 1'b1;
      irq_in[22] = 1'b1; #1;
      chk(vec_addr == addr_of(7) && irq_out, "R8 single slot", 64'(vec_addr), 64'(addr_of(7)));
      irq_in[20] = 1'b1; #1;
      chk(vec_addr == addr_of(3), "R8 lower index wins", 64'(vec_addr), 64'(addr_of(3)));
      slot_enable[3] = 1'b0; #1;
      chk(vec_addr == addr_of(7) && irq_out, "R12 disabled slot", 64'(vec_addr), 64'(addr_of(7)));
      slot_enable[3] = 1'b1;
      tick(1);
   endtask

   task automatic t_nest;
      vec_read = 1'b1; tick(1); vec_read = 1'b0; #1;
      chk(vec_addr == default_addr && !irq_out, "R9 lower held off", 64'(vec_addr), 64'(default_addr));
      irq_in[26] = 1'b1; #1;
      chk(irq_out && vec_addr == default_addr, "R11 non-vectored during service",
          64'(irq_out), 1);
      irq_in[26] = 1'b0;
      irq_in[25] = 1'b1; #1;
      chk(vec_addr == addr_of(1) && irq_out, "R9 higher nests", 64'(vec_addr), 64'(addr_of(1)));
      vec_read = 1'b1; tick(1); vec_read = 1'b0; #1;
      chk(vec_addr == default_addr, "R9 nested in service", 64'(vec_addr), 64'(default_addr));
      eoi = 1'b1; tick(1); eoi = 1'b0; #1;
      chk(vec_addr == addr_of(1), "R10 eoi retires top level", 64'(vec_addr), 64'(addr_of(1)));
      irq_in[25] = 1'b0; #1;
      chk(vec_addr == default_addr && !irq_out, "R10 outer still in service",
          64'(vec_addr), 64'(default_addr));
      eoi = 1'b1; tick(1); eoi = 1'b0; #1;
      chk(vec_addr == addr_of(3) && irq_out, "R10 all retired", 64'(vec_addr), 64'(addr_of(3)));
      irq_in[20] = 1'b0; irq_in[22] = 1'b0;
      tick(1);
   endtask

   initial begin
      for (int s = 0; s < NSL; s++) slot_addr[s] = addr_of(s);
      tick(3);
      rst_n = 1'b1;
      tick(1);
      t_reset();
      t_internal();
      t_route();
      t_ext_level();
      t_ext_edge();
      t_vector();
      t_nest();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #2000000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule